// File: doc/BRIEF.md
# Pseudo dual-port block RAM

This block is a memory with one port that only writes and one port that only reads. Each port runs on its own clock and acts on that clock's rising edge. On the write side, a word is taken in on a write clock edge, together with its address and write strobe. On the read side, the address is taken in on a read clock edge. The read data comes out either straight from the array's read register or through one more pipeline register, and a parameter picks between the two.

A 3-bit select bus acts as the top address bits. Each instance carries a fixed select code. Up to eight instances can therefore share one address space and be stacked in depth: only the instance whose code matches accepts a write, and only that instance drives non-zero read data. The reset is synchronous and active high. It clears the port registers only, and the stored words stay as they were.

Top module: `pdp_ram`

## Requirements
- R1: On a rising `wr_clk` edge, the word on `wr_data` is stored at `wr_addr` when `wr_ce`, `wr_en` and a select match (`wr_sel` == `SEL_CODE`) are all true.
- R2: With `RD_MODE` = direct (0), `rd_data` shows the word at the captured `rd_addr` after one rising `rd_clk` edge with `rd_ce` high.
- R3: With `RD_MODE` = piped (1), the same word reaches `rd_data` one further `rd_clk` edge with `rd_ce` high later. Until then `rd_data` keeps its previous value.
- R4: While `rst` is high, `rd_data` goes to zero in both read modes. Words stored before the reset read back unchanged after it.
- R5: A write whose `wr_sel` differs from `SEL_CODE` leaves the array unchanged.
- R6: A read captured with `rd_sel` different from `SEL_CODE` gives `rd_data` equal to zero.
- R7: While `rd_ce` is low, the read registers hold their values. `rd_data` does not change when the address, the select or the addressed word changes.
- R8: While `wr_ce` is low, no write takes place, even with `wr_en` high.
- R9: When the same clock edge writes a word and captures a read of that address, the read returns the old contents.
- R10: While `wr_en` is low, no write takes place.
- R11: A write presented while `rst` is high is not performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset of the port registers |
| wr_clk | input | 1 | Write port clock |
| wr_ce | input | 1 | Write port clock enable |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write select, top address bits |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Word to store |
| rd_clk | input | 1 | Read port clock |
| rd_ce | input | 1 | Read port clock enable |
| rd_sel | input | 3 | Read select, top address bits |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Read word, zero when the captured select missed |

## Verification
The bench goes after the cases where a gate is skipped.

- **Ignored write:** a write with a wrong select, a low clock enable, a low strobe, or a raised reset must leave an earlier word intact. A design that ignored any one of these gates would read back the overwriting value.
- **Held read port:** with the read enable low, the bench changes the address and overwrites the addressed word. A design that let the registers follow would show the new word.
- **Reset:** the bench resets between writes and reads. A design that cleared the array would return zeros.
- **Same-edge read and write:** a shared-clock instance reads and writes one address on the same edge. A write-first design would return the new word one edge too early.
- **Read latency:** the two read modes are compared edge by edge. An off-by-one pipeline would show the wrong word at the first sample.

// File: rtl/pdp_ram_pkg.sv
package pdp_ram_pkg;

    localparam int SEL_W = 3;

    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic {
        RD_DIRECT = 1'b0,
        RD_PIPED  = 1'b1
    } rd_mode_e;

    function automatic logic sel_hit(input sel_t got, input sel_t own);
        return got == own;
    endfunction

endpackage

// File: rtl/pdp_wr_port.sv
module pdp_wr_port
    import pdp_ram_pkg::*;
#(
    parameter int   ADDR_W   = 8,
    parameter int   DATA_W   = 16,
    parameter sel_t SEL_CODE = '0
) (
    input  logic              rst,
    input  logic              wr_ce,
    input  logic              wr_en,
    input  sel_t              wr_sel,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata
);

    typedef struct packed {
        logic              go;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    wr_req_t req;

    always_comb begin
        req.go   = !rst && wr_ce && wr_en && sel_hit(wr_sel, SEL_CODE);
        req.addr = wr_addr;
        req.data = wr_data;
    end

    assign mem_we    = req.go;
    assign mem_waddr = req.addr;
    assign mem_wdata = req.data;

endmodule

// File: rtl/pdp_mem_array.sv
module pdp_mem_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              wr_clk,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_waddr,
    input  logic [DATA_W-1:0] mem_wdata,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              rd_ce,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Array contents are never reset.
    always_ff @(posedge wr_clk) begin
        if (mem_we) begin
            mem[mem_waddr] <= mem_wdata;
        end
    end

    // Read address is taken in here; a same-edge write is not yet visible.
    always_ff @(posedge rd_clk) begin
        if (rst) begin
            rd_word <= '0;
        end else if (rd_ce) begin
            rd_word <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/pdp_rd_port.sv
module pdp_rd_port
    import pdp_ram_pkg::*;
#(
    parameter int       DATA_W   = 16,
    parameter sel_t     SEL_CODE = '0,
    parameter rd_mode_e RD_MODE  = RD_DIRECT
) (
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              rd_ce,
    input  sel_t              rd_sel,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] pre_data,
    output logic [DATA_W-1:0] rd_data
);

    logic hit_q;

    always_ff @(posedge rd_clk) begin
        if (rst) begin
            hit_q <= 1'b0;
        end else if (rd_ce) begin
            hit_q <= sel_hit(rd_sel, SEL_CODE);
        end
    end

    assign pre_data = hit_q ? rd_word : '0;

    generate
        if (RD_MODE == RD_PIPED) begin : g_piped
            logic [DATA_W-1:0] out_q;
            always_ff @(posedge rd_clk) begin
                if (rst) begin
                    out_q <= '0;
                end else if (rd_ce) begin
                    out_q <= pre_data;
                end
            end
            assign rd_data = out_q;
        end else begin : g_direct
            assign rd_data = pre_data;
        end
    endgenerate

endmodule

// File: rtl/pdp_ram.sv
module pdp_ram
    import pdp_ram_pkg::*;
#(
    parameter int       ADDR_W   = 8,
    parameter int       DATA_W   = 16,
    parameter sel_t     SEL_CODE = '0,
    parameter rd_mode_e RD_MODE  = RD_DIRECT
) (
    input  logic              rst,
    input  logic              wr_clk,
    input  logic              wr_ce,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_ce,
    input  logic [2:0]        rd_sel,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] pre_data;

    pdp_wr_port #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SEL_CODE(SEL_CODE)
    ) u_wr (
        .rst      (rst),
        .wr_ce    (wr_ce),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mem_we   (mem_we),
        .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata)
    );

    pdp_mem_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_arr (
        .wr_clk   (wr_clk),
        .mem_we   (mem_we),
        .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata),
        .rd_clk   (rd_clk),
        .rst      (rst),
        .rd_ce    (rd_ce),
        .rd_addr  (rd_addr),
        .rd_word  (rd_word)
    );

    pdp_rd_port #(
        .DATA_W  (DATA_W),
        .SEL_CODE(SEL_CODE),
        .RD_MODE (RD_MODE)
    ) u_rd (
        .rd_clk  (rd_clk),
        .rst     (rst),
        .rd_ce   (rd_ce),
        .rd_sel  (rd_sel),
        .rd_word (rd_word),
        .pre_data(pre_data),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/pdp_ram_chk.sv
module pdp_ram_chk
    import pdp_ram_pkg::*;
#(
    parameter int       DATA_W   = 16,
    parameter sel_t     SEL_CODE = '0,
    parameter rd_mode_e RD_MODE  = RD_DIRECT
) (
    input logic              rst,
    input logic              wr_clk,
    input logic              wr_ce,
    input logic [2:0]        wr_sel,
    input logic              mem_we,
    input logic              rd_clk,
    input logic              rd_ce,
    input logic [2:0]        rd_sel,
    input logic [DATA_W-1:0] pre_data,
    input logic [DATA_W-1:0] rd_data
);

    p_reset_zero_r4: assert property (@(posedge rd_clk) disable iff (rst)
        $fell(rst) |-> rd_data == '0);

    p_hold_ce_r7: assert property (@(posedge rd_clk) disable iff (rst)
        !rd_ce |=> $stable(rd_data));

    p_wr_sel_gate_r5: assert property (@(posedge wr_clk) disable iff (rst)
        (wr_sel != SEL_CODE) |-> !mem_we);

    p_wr_ce_gate_r8: assert property (@(posedge wr_clk) disable iff (rst)
        !wr_ce |-> !mem_we);

    generate
        if (RD_MODE == RD_PIPED) begin : g_piped_chk
            p_piped_lag_r3: assert property (@(posedge rd_clk) disable iff (rst)
                rd_ce |=> rd_data == $past(pre_data));
            p_miss_zero_r6: assert property (@(posedge rd_clk) disable iff (rst)
                (rd_ce && rd_sel != SEL_CODE) ##1 rd_ce |=> rd_data == '0);
        end else begin : g_direct_chk
            p_miss_zero_r6: assert property (@(posedge rd_clk) disable iff (rst)
                (rd_ce && rd_sel != SEL_CODE) |=> rd_data == '0);
        end
    endgenerate

endmodule

bind pdp_ram pdp_ram_chk #(
    .DATA_W  (DATA_W),
    .SEL_CODE(SEL_CODE),
    .RD_MODE (RD_MODE)
) u_chk (
    .rst     (rst),
    .wr_clk  (wr_clk),
    .wr_ce   (wr_ce),
    .wr_sel  (wr_sel),
    .mem_we  (mem_we),
    .rd_clk  (rd_clk),
    .rd_ce   (rd_ce),
    .rd_sel  (rd_sel),
    .pre_data(pre_data),
    .rd_data (rd_data)
);

// File: tb/pdp_ram_tb.sv
module pdp_ram_tb_top;
    import pdp_ram_pkg::*;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam logic [2:0] OWN = 3'd5;
    localparam logic [2:0] OTHER = 3'd2;

    logic clk = 1'b0;
    logic rclk = 1'b0;
    logic rst = 1'b1;

    logic          wce = 0, wen = 0;
    logic [2:0]    wsel = 0;
    logic [AW-1:0] waddr = 0;
    logic [DW-1:0] wdata = 0;
    logic          rce = 0;
    logic [2:0]    rsel = 0;
    logic [AW-1:0] raddr = 0;
    logic [DW-1:0] q_dir, q_pip;

    logic          s_wen = 0, s_rce = 0;
    logic [AW-1:0] s_waddr = 0, s_raddr = 0;
    logic [DW-1:0] s_wdata = 0;
    logic [DW-1:0] q_s;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [DW-1:0] last_p = '0;

    initial forever #10 clk = ~clk;
    initial begin
        #6;
        forever #10 rclk = ~rclk;
    end

    pdp_ram #(.ADDR_W(AW), .DATA_W(DW), .SEL_CODE(OWN), .RD_MODE(RD_DIRECT)) dut_i (
        .rst(rst), .wr_clk(clk), .wr_ce(wce), .wr_en(wen), .wr_sel(wsel),
        .wr_addr(waddr), .wr_data(wdata), .rd_clk(rclk), .rd_ce(rce),
        .rd_sel(rsel), .rd_addr(raddr), .rd_data(q_dir));

    pdp_ram #(.ADDR_W(AW), .DATA_W(DW), .SEL_CODE(OWN), .RD_MODE(RD_PIPED)) dut_p (
        .rst(rst), .wr_clk(clk), .wr_ce(wce), .wr_en(wen), .wr_sel(wsel),
        .wr_addr(waddr), .wr_data(wdata), .rd_clk(rclk), .rd_ce(rce),
        .rd_sel(rsel), .rd_addr(raddr), .rd_data(q_pip));

    pdp_ram #(.ADDR_W(AW), .DATA_W(DW), .SEL_CODE(OWN), .RD_MODE(RD_DIRECT)) dut_s (
        .rst(rst), .wr_clk(clk), .wr_ce(1'b1), .wr_en(s_wen), .wr_sel(OWN),
        .wr_addr(s_waddr), .wr_data(s_wdata), .rd_clk(clk), .rd_ce(s_rce),
        .rd_sel(OWN), .rd_addr(s_raddr), .rd_data(q_s));

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [2:0] s,
                       input logic ce, input logic en);
        @(negedge clk);
        wce = ce; wen = en; wsel = s; waddr = a; wdata = d;
        @(negedge clk);
        wce = 0; wen = 0;
    endtask

    // Direct output checked after one edge, piped output after two.
    task automatic get(input logic [AW-1:0] a, input logic [2:0] s, input logic [DW-1:0] exp,
                       input string tag);
        @(negedge rclk);
        raddr = a; rsel = s; rce = 1;
        @(negedge rclk);
        chk({tag, " direct R2"}, q_dir, exp);
        chk({tag, " piped lag R3"}, q_pip, last_p);
        @(negedge rclk);
        chk({tag, " piped R3"}, q_pip, exp);
        rce = 0;
        last_p = exp;
    endtask

    task automatic t_reset_state();
        repeat (4) @(negedge clk);
        chk("reset direct R4", q_dir, '0);
        chk("reset piped R4", q_pip, '0);
        rst = 0;
    endtask

    task automatic t_basic();
        put(8'h00, 16'hA5A5, OWN, 1, 1);
        put(8'hFF, 16'h5A5A, OWN, 1, 1);
        put(8'h3C, 16'h0001, OWN, 1, 1);
        put(8'h03, 16'h1234, OWN, 1, 1);
        get(8'h00, OWN, 16'hA5A5, "addr00 R1");
        get(8'hFF, OWN, 16'h5A5A, "addrFF R1");
        get(8'h3C, OWN, 16'h0001, "addr3C R1");
    endtask

    task automatic t_ignored_writes();
        put(8'h03, 16'hDEAD, OTHER, 1, 1);
        get(8'h03, OWN, 16'h1234, "wr_sel miss R5");
        put(8'h03, 16'hBEEF, OWN, 0, 1);
        get(8'h03, OWN, 16'h1234, "wr_ce low R8");
        put(8'h03, 16'hCAFE, OWN, 1, 0);
        get(8'h03, OWN, 16'h1234, "wr_en low R10");
    endtask

    task automatic t_read_miss();
        get(8'h00, OTHER, 16'h0000, "rd_sel miss R6");
        get(8'h00, OWN, 16'hA5A5, "rd_sel hit again R6");
    endtask

    task automatic t_read_hold();
        get(8'h3C, OWN, 16'h0001, "hold setup R7");
        @(negedge rclk);
        raddr = 8'hFF; rsel = OTHER; rce = 0;
        put(8'h3C, 16'h7777, OWN, 1, 1);
        repeat (3) @(negedge rclk);
        chk("ce low direct R7", q_dir, 16'h0001);
        chk("ce low piped R7", q_pip, 16'h0001);
        get(8'h3C, OWN, 16'h7777, "after hold R7");
    endtask

    task automatic t_reset_keeps();
        @(negedge clk);
        rst = 1;
        wce = 1; wen = 1; wsel = OWN; waddr = 8'h00; wdata = 16'h9999;
        repeat (3) @(negedge clk);
        wce = 0; wen = 0;
        @(negedge rclk);
        chk("in reset direct R4", q_dir, '0);
        chk("in reset piped R4", q_pip, '0);
        @(negedge clk);
        rst = 0;
        last_p = '0;
        get(8'hFF, OWN, 16'h5A5A, "kept after reset R4");
        get(8'h00, OWN, 16'hA5A5, "write in reset R11");
    endtask

    task automatic t_same_edge();
        @(negedge clk);
        s_wen = 1; s_waddr = 8'h09; s_wdata = 16'h1111; s_rce = 0;
        @(negedge clk);
        s_wdata = 16'h2222; s_raddr = 8'h09; s_rce = 1;
        @(negedge clk);
        chk("same edge old word R9", q_s, 16'h1111);
        s_wen = 0;
        @(negedge clk);
        chk("next edge new word R9", q_s, 16'h2222);
        s_rce = 0;
    endtask

    initial begin
        t_reset_state();
        t_basic();
        t_ignored_writes();
        t_read_miss();
        t_read_hold();
        t_reset_keeps();
        t_same_edge();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog all: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule